// File: doc/BRIEF.md
# Multiplexed Latching Bus Exchange

This block joins one common 12-bit port (side A) to two banked 12-bit ports (bank 1 and bank 2). Data going from A toward the banks passes through one storage latch per bank. Data coming back from the banks passes through one storage latch per bank, and a select input then picks which of those two latches drives side A. Each port has an active-low output enable. The two bank enables give bank control in the A-to-B direction: A-side data can reach bank 1, bank 2, both or neither.

Every latch is level-sensitive and is modelled around the block clock. While its enable is high, the latch output follows its input in the same cycle. While its enable is low, the latch output holds the input value that was sampled at the last rising clock edge at which the enable was high.

Bidirectional pins are split into an input vector, an output vector and a per-bit drive-enable vector. Each input carries a driver-valid flag. A per-port hold register keeps the last driven value, so a port with no driver still presents a valid level to the latches. The notes on design choices use the words "state" and "transition" only for the latch modes, which are open (transparent) or closed (holding). A latch moves from open to closed at a rising clock edge where its enable is low, and back to open as soon as its enable is high.

Top module: `xbus_mux_latch`

## Requirements
- R1: The asynchronous active-low reset clears all four latches and all three hold registers to zero. After reset, with all latch enables low and no input driven, every enabled output reads zero.
- R2: Each port output enable is active-low.
  - When it is high, that port's drive-enable vector is all zeros and its output data reads zero.
  - When it is low, the drive-enable vector is all ones.
- R3: The two bank output enables act independently. Each bank port shows its own A-to-B latch output exactly when its own enable is low, whatever the other bank's enable is.
- R4: While an A-to-B latch enable (`le_ab1`, `le_ab2`) is high, the matching bank output equals the current effective A-side input in the same cycle.
- R5: While an A-to-B latch enable is low, the matching bank output equals the effective A-side input sampled at the last rising clock edge at which that enable was high. The value is kept until the enable returns high.
- R6: `sel` = 0 routes the bank-1-to-A latch to the A output, and `sel` = 1 routes the bank-2-to-A latch.
- R7: The B-to-A latches (`le_b1a`, `le_b2a`) are transparent and capture in the same way as the A-to-B latches, each fed from its own bank's effective input.
- R8: A port's effective input follows the port input while its driver-valid flag is high. While the flag is low, the effective input is the value sampled at the last rising clock edge at which the flag was high, or zero if there has been no such edge since reset.
- R9: Both directions store independently and at the same time. Loading or holding in one direction never disturbs the latches of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 12 | Side A pin input |
| a_drv | input | 1 | Side A external driver valid |
| a_out | output | 12 | Side A pin output data |
| a_oe | output | 12 | Side A per-bit drive enable |
| b1_in | input | 12 | Bank 1 pin input |
| b1_drv | input | 1 | Bank 1 external driver valid |
| b1_out | output | 12 | Bank 1 pin output data |
| b1_oe | output | 12 | Bank 1 per-bit drive enable |
| b2_in | input | 12 | Bank 2 pin input |
| b2_drv | input | 1 | Bank 2 external driver valid |
| b2_out | output | 12 | Bank 2 pin output data |
| b2_oe | output | 12 | Bank 2 per-bit drive enable |
| oe_a_n | input | 1 | Side A output enable, active low |
| oe_b1_n | input | 1 | Bank 1 output enable, active low |
| oe_b2_n | input | 1 | Bank 2 output enable, active low |
| le_ab1 | input | 1 | A-to-bank-1 latch enable, high = transparent |
| le_ab2 | input | 1 | A-to-bank-2 latch enable, high = transparent |
| le_b1a | input | 1 | Bank-1-to-A latch enable, high = transparent |
| le_b2a | input | 1 | Bank-2-to-A latch enable, high = transparent |
| sel | input | 1 | Return-path select: 0 = bank 1, 1 = bank 2 |

## Verification
Two functions can fall in the same cycle: a latch can close while the bus-hold register of its own port takes over from a released driver, and a latch in the other direction can load new data on that same edge. Both cases are provoked by dropping a driver-valid flag and a latch enable at one clock edge, while the opposite-direction enables stay open and the data changes. A long pseudo-random phase repeats this in many mixes. Each output is judged against a behavioural model in the bench. The model recomputes the effective inputs and the latched values from the requirements on every clock.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int XB_WIDTH = 12;
    localparam int XB_BANKS = 2;

    typedef enum logic {
        LAT_CLOSED = 1'b0,
        LAT_OPEN   = 1'b1
    } lat_mode_e;
endpackage

// File: rtl/xbus_hold.sv
module xbus_hold #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         drv,
    input  logic [W-1:0] pin,
    output logic [W-1:0] eff
);
    logic [W-1:0] kept_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kept_q <= '0;
        end else if (drv) begin
            kept_q <= pin;
        end
    end

    always_comb begin
        eff = drv ? pin : kept_q;
    end
endmodule

// File: rtl/xbus_latch.sv
module xbus_latch
    import xbus_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    lat_mode_e    mode;
    logic [W-1:0] store_q;

    always_comb begin
        mode = le ? LAT_OPEN : LAT_CLOSED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            unique case (mode)
                LAT_OPEN:   store_q <= d;
                LAT_CLOSED: store_q <= store_q;
            endcase
        end
    end

    always_comb begin
        unique case (mode)
            LAT_OPEN:   q = d;
            LAT_CLOSED: q = store_q;
        endcase
    end
endmodule

// File: rtl/xbus_drive.sv
module xbus_drive #(
    parameter int W = 12
) (
    input  logic         oe_n,
    input  logic [W-1:0] val,
    output logic [W-1:0] out,
    output logic [W-1:0] oe
);
    always_comb begin
        oe  = {W{~oe_n}};
        out = oe_n ? '0 : val;
    end
endmodule

// File: rtl/xbus_mux_latch.sv
module xbus_mux_latch
    import xbus_pkg::*;
#(
    parameter int W = XB_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic         a_drv,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b1_in,
    input  logic         b1_drv,
    output logic [W-1:0] b1_out,
    output logic [W-1:0] b1_oe,
    input  logic [W-1:0] b2_in,
    input  logic         b2_drv,
    output logic [W-1:0] b2_out,
    output logic [W-1:0] b2_oe,
    input  logic         oe_a_n,
    input  logic         oe_b1_n,
    input  logic         oe_b2_n,
    input  logic         le_ab1,
    input  logic         le_ab2,
    input  logic         le_b1a,
    input  logic         le_b2a,
    input  logic         sel
);
    localparam int NB = XB_BANKS;

    logic [W-1:0] a_eff;
    logic [W-1:0] bk_in    [NB];
    logic         bk_drv   [NB];
    logic         bk_oe_n  [NB];
    logic         bk_le_ab [NB];
    logic         bk_le_ba [NB];
    logic [W-1:0] bk_eff   [NB];
    logic [W-1:0] ab_q     [NB];
    logic [W-1:0] ba_q     [NB];
    logic [W-1:0] bk_out   [NB];
    logic [W-1:0] bk_oe    [NB];
    logic [W-1:0] a_val;

    always_comb begin
        bk_in[0]    = b1_in;
        bk_in[1]    = b2_in;
        bk_drv[0]   = b1_drv;
        bk_drv[1]   = b2_drv;
        bk_oe_n[0]  = oe_b1_n;
        bk_oe_n[1]  = oe_b2_n;
        bk_le_ab[0] = le_ab1;
        bk_le_ab[1] = le_ab2;
        bk_le_ba[0] = le_b1a;
        bk_le_ba[1] = le_b2a;
    end

    xbus_hold #(.W(W)) u_hold_a (
        .clk   (clk),
        .rst_n (rst_n),
        .drv   (a_drv),
        .pin   (a_in),
        .eff   (a_eff)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        xbus_hold #(.W(W)) u_hold (
            .clk   (clk),
            .rst_n (rst_n),
            .drv   (bk_drv[g]),
            .pin   (bk_in[g]),
            .eff   (bk_eff[g])
        );

        xbus_latch #(.W(W)) u_lat_ab (
            .clk   (clk),
            .rst_n (rst_n),
            .le    (bk_le_ab[g]),
            .d     (a_eff),
            .q     (ab_q[g])
        );

        xbus_latch #(.W(W)) u_lat_ba (
            .clk   (clk),
            .rst_n (rst_n),
            .le    (bk_le_ba[g]),
            .d     (bk_eff[g]),
            .q     (ba_q[g])
        );

        xbus_drive #(.W(W)) u_drv (
            .oe_n  (bk_oe_n[g]),
            .val   (ab_q[g]),
            .out   (bk_out[g]),
            .oe    (bk_oe[g])
        );
    end

    always_comb begin
        a_val = sel ? ba_q[1] : ba_q[0];
    end

    xbus_drive #(.W(W)) u_drv_a (
        .oe_n  (oe_a_n),
        .val   (a_val),
        .out   (a_out),
        .oe    (a_oe)
    );

    always_comb begin
        b1_out = bk_out[0];
        b1_oe  = bk_oe[0];
        b2_out = bk_out[1];
        b2_oe  = bk_oe[1];
    end
endmodule

// File: rtl/xbus_mux_latch_chk.sv
module xbus_mux_latch_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic         a_drv,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b1_out,
    input logic [W-1:0] b2_in,
    input logic         b2_drv,
    input logic         oe_a_n,
    input logic         oe_b1_n,
    input logic         le_ab1,
    input logic         le_b2a,
    input logic         sel
);
    // R2
    a_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_a_n |-> (a_oe == '0 && a_out == '0));

    // R4
    ab1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le_ab1 && !oe_b1_n && a_drv) |-> (b1_out == a_in));

    // R5
    ab1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_ab1 && $past(!le_ab1) && !oe_b1_n && $past(!oe_b1_n))
            |-> $stable(b1_out));

    // R6
    sel_bank2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a_n && sel && le_b2a && b2_drv) |-> (a_out == b2_in));

    // R8
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_drv && $past(a_drv) && le_ab1 && !oe_b1_n)
            |-> (b1_out == $past(a_in)));
endmodule

bind xbus_mux_latch xbus_mux_latch_chk #(.W(W)) chk (.*);

// File: tb/xbus_mux_latch_test.sv
`timescale 1ns/1ps
module xbus_mux_latch_test;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic         a_drv = 1'b0, b1_drv = 1'b0, b2_drv = 1'b0;
    logic         oe_a_n = 1'b0, oe_b1_n = 1'b0, oe_b2_n = 1'b0;
    logic         le_ab1 = 1'b0, le_ab2 = 1'b0, le_b1a = 1'b0, le_b2a = 1'b0;
    logic         sel = 1'b0;
    logic [W-1:0] a_out, a_oe, b1_out, b1_oe, b2_out, b2_oe;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string tag = "R1 reset";

    // behavioural reference state
    logic [W-1:0] m_ha = '0, m_hb1 = '0, m_hb2 = '0;
    logic [W-1:0] m_ab1 = '0, m_ab2 = '0, m_b1a = '0, m_b2a = '0;

    always #4 clk = ~clk;

    xbus_mux_latch uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
        .b1_in(b1_in), .b1_drv(b1_drv), .b1_out(b1_out), .b1_oe(b1_oe),
        .b2_in(b2_in), .b2_drv(b2_drv), .b2_out(b2_out), .b2_oe(b2_oe),
        .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n), .oe_b2_n(oe_b2_n),
        .le_ab1(le_ab1), .le_ab2(le_ab2), .le_b1a(le_b1a), .le_b2a(le_b2a),
        .sel(sel)
    );

    always @(posedge clk or negedge rst_n) begin
        logic [W-1:0] ea, e1, e2;
        if (!rst_n) begin
            m_ha = '0; m_hb1 = '0; m_hb2 = '0;
            m_ab1 = '0; m_ab2 = '0; m_b1a = '0; m_b2a = '0;
        end else begin
            ea = a_drv ? a_in : m_ha;
            e1 = b1_drv ? b1_in : m_hb1;
            e2 = b2_drv ? b2_in : m_hb2;
            if (le_ab1) m_ab1 = ea;
            if (le_ab2) m_ab2 = ea;
            if (le_b1a) m_b1a = e1;
            if (le_b2a) m_b2a = e2;
            m_ha = ea; m_hb1 = e1; m_hb2 = e2;
        end
    end

    task automatic check(string what, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [W-1:0] ea, e1, e2, xa, x1, x2;
        ea = a_drv ? a_in : m_ha;
        e1 = b1_drv ? b1_in : m_hb1;
        e2 = b2_drv ? b2_in : m_hb2;
        x1 = oe_b1_n ? '0 : (le_ab1 ? ea : m_ab1);
        x2 = oe_b2_n ? '0 : (le_ab2 ? ea : m_ab2);
        if (oe_a_n) xa = '0;
        else if (sel) xa = le_b2a ? e2 : m_b2a;
        else xa = le_b1a ? e1 : m_b1a;
        check("b1_out", b1_out, x1);
        check("b2_out", b2_out, x2);
        check("a_out", a_out, xa);
        check("b1_oe", b1_oe, {W{~oe_b1_n}});
        check("b2_oe", b2_oe, {W{~oe_b2_n}});
        check("a_oe", a_oe, {W{~oe_a_n}});
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #3;
            compare();
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        a_in = 12'hABC; b1_in = 12'h123; b2_in = 12'h456;
        repeat (3) @(posedge clk);
        #3;
        compare();
        rst_n = 1'b1;
        step(2);
        // R1: direct reset-state check
        check("R1 b1_out after reset", b1_out, 12'h000);
        check("R1 a_out after reset", a_out, 12'h000);

        tag = "R2 output enables";
        oe_a_n = 1'b1; oe_b1_n = 1'b1; oe_b2_n = 1'b1; le_ab1 = 1'b1; a_drv = 1'b1;
        step(2);
        check("R2 b1_oe off", b1_oe, 12'h000);
        oe_a_n = 1'b0; oe_b1_n = 1'b0; oe_b2_n = 1'b0;
        step(1);
        check("R2 b1_oe on", b1_oe, 12'hFFF);

        tag = "R4 transparency";
        le_ab2 = 1'b1;
        for (int k = 0; k < 6; k++) begin
            a_in = 12'h111 * (k + 1);
            step(1);
        end
        check("R4 b2 follows", b2_out, 12'h666);

        tag = "R5 capture";
        a_in = 12'h5A5;
        step(1);
        le_ab1 = 1'b0;
        a_in = 12'h0F0;
        step(3);
        check("R5 b1 held", b1_out, 12'h5A5);
        check("R5 b2 open", b2_out, 12'h0F0);
        le_ab1 = 1'b1;
        step(1);
        check("R5 b1 reopened", b1_out, 12'h0F0);

        tag = "R3 bank gating";
        oe_b1_n = 1'b1;
        step(2);
        check("R3 b1 off b2 on", b2_out, 12'h0F0);
        oe_b1_n = 1'b0; oe_b2_n = 1'b1;
        step(2);
        check("R3 b1 on b2 off", b1_out, 12'h0F0);
        oe_b1_n = 1'b1;
        step(1);
        oe_b1_n = 1'b0; oe_b2_n = 1'b0;
        step(1);

        tag = "R8 bus hold";
        a_in = 12'h3C3;
        step(1);
        a_drv = 1'b0;
        a_in = 12'hFFF;
        step(3);
        check("R8 a hold", b1_out, 12'h3C3);
        a_drv = 1'b1;
        step(1);

        tag = "R6 R7 return path";
        b1_drv = 1'b1; b2_drv = 1'b1; le_b1a = 1'b1; le_b2a = 1'b1;
        b1_in = 12'h1A1; b2_in = 12'h2B2;
        sel = 1'b0;
        step(1);
        check("R6 sel0", a_out, 12'h1A1);
        sel = 1'b1;
        step(1);
        check("R6 sel1", a_out, 12'h2B2);
        le_b2a = 1'b0;
        b2_in = 12'h777;
        step(2);
        check("R7 b2a held", a_out, 12'h2B2);
        sel = 1'b0;
        b1_in = 12'h888;
        step(1);
        check("R7 b1a open", a_out, 12'h888);

        tag = "R9 both directions";
        le_ab1 = 1'b1; le_b1a = 1'b1; a_in = 12'h246; b1_in = 12'h135;
        step(1);
        le_ab1 = 1'b0; a_drv = 1'b0; a_in = 12'h000;
        b1_in = 12'h9AB;
        step(2);
        check("R9 ab1 held", b1_out, 12'h246);
        check("R9 b1a open", a_out, 12'h9AB);
        le_b1a = 1'b0; le_ab1 = 1'b1; a_drv = 1'b1; a_in = 12'hCDE;
        b1_in = 12'h000;
        step(2);
        check("R9 b1a held", a_out, 12'h9AB);
        check("R9 ab1 open", b1_out, 12'hCDE);

        tag = "R9 mixed random";
        lf = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            {le_ab1, le_ab2, le_b1a, le_b2a} = lf[3:0];
            {a_drv, b1_drv, b2_drv, sel} = lf[7:4];
            {oe_a_n, oe_b1_n, oe_b2_n} = (lf[10:8] == 3'b111) ? 3'b000 : lf[10:8];
            a_in = {lf[11:0]} ^ 12'h5C3;
            b1_in = {lf[15:4]};
            b2_in = {lf[7:0], lf[15:12]};
            step(1);
        end

        tag = "R1 reset again";
        rst_n = 1'b0;
        oe_a_n = 1'b0; oe_b1_n = 1'b0; oe_b2_n = 1'b0;
        le_ab1 = 1'b0; le_ab2 = 1'b0; le_b1a = 1'b0; le_b2a = 1'b0;
        a_drv = 1'b0; b1_drv = 1'b0; b2_drv = 1'b0;
        #3;
        compare();
        rst_n = 1'b1;
        step(2);
        check("R1 b2_out zero", b2_out, 12'h000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule